// File: doc/BRIEF.md
# Register-file target for a serial two-wire bus, with pointer auto-increment

This block is the host-facing front end of an eight-channel LED driver. It listens on an I2C bus (SCL plus an open-drain SDA, modelled as an input and a pull-low enable) and answers to one 7-bit address. The upper four bits of that address are fixed and the lower three come from strap pins. A write transfer carries a pointer byte followed by any number of data bytes. A read transfer sets the pointer with a short write, then issues a repeated START and clocks register data out.

The pointer byte holds a four-bit register index and one auto-advance flag. With the flag set, the pointer steps after every byte. The wrap target differs by direction: a write sequence wraps back to the first writable location, while a read sequence wraps to location zero. Location zero reflects the live LED pin levels and location one is hard zero; both take writes without effect. Locations eight and nine are scratch storage. The six control bytes, which are two period prescalers, two duty values and two channel-selector bytes, are presented in parallel to the LED engine. Both bus lines pass through a synchronizer and a stability filter, so short spikes are rejected.

Top module: `ledi2c_target`

## Requirements
- R1: A START (filtered SDA falling while SCL is high) aborts any transfer in progress, including one in the middle of a byte, and begins a new address phase. A STOP (SDA rising while SCL is high) returns the target to idle.
- R2: The target acknowledges an address byte by pulling SDA low for the 9th clock only when its upper seven bits equal {4'b1100, addr_sel_i}. Bit 0 of that byte selects the direction: 0 is write and 1 is read.
- R3: After a non-matching address, the target acknowledges nothing and leaves SDA released until the next START. Data that follows does not change any register.
- R4: In a write transfer, the target acknowledges the pointer byte and every data byte. In the pointer byte, bits 3:0 are the register index and bit 4 is the auto-advance flag. Each data byte goes to the location the pointer currently selects.
- R5: With the flag set, the write pointer steps after each data byte and goes from 0x09 (or any index above it) to 0x02.
- R6: With the flag clear, every data byte of a write lands in the same register, and every byte of a read returns the same register.
- R7: A read (address byte with bit 0 = 1) shifts out the selected register MSB first. The target changes SDA only while SCL is low. With the flag set, the pointer steps after each byte and goes from 0x09 (or above) to 0x00.
- R8: Writes to 0x00, 0x01 and 0x0A–0x0F are acknowledged and discarded. Reads return pin_state_i at 0x00 and 0x00 at 0x01 and 0x0A–0x0F.
- R9: After reset, every stored register is 0x00 except 0x03 and 0x05, which are 0x80. The outputs map to 0x02 (prescale0), 0x03 (duty0), 0x04 (prescale1), 0x05 (duty1), 0x06 (select_lo) and 0x07 (select_hi).
- R10: A master NACK after a read byte ends the read. SDA stays released for any further clocks until STOP or START.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R12: Locations 0x08 and 0x09 store written data and return it on read. They do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| addr_sel_i | input | 3 | Low three bits of the device address |
| pin_state_i | input | 8 | Live LED pin levels, read at location 0x00 |
| prescale0_o | output | 8 | Period prescaler, channel group 0 |
| duty0_o | output | 8 | Duty value, group 0 |
| prescale1_o | output | 8 | Period prescaler, group 1 |
| duty1_o | output | 8 | Duty value, group 1 |
| select_lo_o | output | 8 | Mode selector for LEDs 0–3 |
| select_hi_o | output | 8 | Mode selector for LEDs 4–7 |

## Verification
The bench sweeps all 128 address bytes. A comparator that ignored the strap pins or the fixed prefix would acknowledge the wrong ones. It then writes and reads back from every one of the sixteen pointer values with auto-advance set. A single shared wrap point, or a pointer that stopped at 0x09, would return wrong bytes at the end of the map. Separate cases cover the following: a fixed pointer (a design that always advanced would spread the bytes), writes into read-only and unmapped locations (a design that stored them would change an output or a readback), a repeated START in mid-byte (a design that kept the partial byte would store it), a NACK followed by extra clocks (a design that kept shifting would pull SDA), and short spikes on both lines (an unfiltered design would count a phantom clock or see a false START).

// File: rtl/ledi2c_pkg.sv
package ledi2c_pkg;

    localparam int          PTR_W      = 4;
    localparam logic [3:0]  REG_LAST   = 4'd9;
    localparam logic [3:0]  RW_FIRST   = 4'd2;
    localparam logic [3:0]  WR_WRAP    = 4'd2;
    localparam logic [3:0]  RD_WRAP    = 4'd0;
    localparam int          NUM_RW     = 8;
    localparam int          CTL_NUM    = 6;
    localparam int          INC_BIT    = 4;
    localparam logic [3:0]  DEV_HI     = 4'b1100;
    localparam logic [7:0]  DUTY_RESET = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_PTR, ST_WR, ST_ACK, ST_RD, ST_MACK
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        phase_e      after_ack;
        logic [3:0]  cnt;
        logic [7:0]  shreg;
        logic [3:0]  ptr;
        logic        inc;
        logic        macked;
        logic        pull;
        logic        scl_p;
        logic        sda_p;
        logic        we;
        logic [3:0]  waddr;
        logic [7:0]  wdata;
    } ctl_s;

endpackage

// File: rtl/ledi2c_deglitch.sv
module ledi2c_deglitch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } flt_s;

    flt_s f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.sync = {f_q.sync[0], din};
        if (f_q.sync[1] == f_q.out) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == CW'(LEN - 1)) begin
            f_d.out = f_q.sync[1];
            f_d.cnt = '0;
        end else begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.sync <= 2'b11;
            f_q.cnt  <= '0;
            f_q.out  <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout = f_q.out;

    // R11
    glitch_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q.out) |-> ($past(f_q.sync[1]) == f_q.out && $past(f_q.sync[1], 2) == f_q.out));

    initial begin
        if (LEN < 2) $error("LEN must be at least 2");
    end
endmodule

// File: rtl/ledi2c_regbank.sv
module ledi2c_regbank
    import ledi2c_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [PTR_W-1:0]        wr_addr_i,
    input  logic [7:0]              wr_data_i,
    input  logic [PTR_W-1:0]        rd_addr_i,
    input  logic [7:0]              pin_state_i,
    output logic [7:0]              rd_data_o,
    output logic [CTL_NUM-1:0][7:0] ctl_o
);
    localparam int SLOT_W = $clog2(NUM_RW);

    function automatic logic [7:0] reset_val(input int a);
        return (a == 3 || a == 5) ? DUTY_RESET : 8'h00;
    endfunction

    logic [7:0]            mem_q [NUM_RW];
    logic [7:0]            mem_d [NUM_RW];
    logic [SLOT_W-1:0]     wslot, rslot;
    logic                  w_hit, r_hit;
    logic [NUM_RW*8-1:0]   mem_flat;

    assign w_hit = (wr_addr_i >= RW_FIRST) && (wr_addr_i <= REG_LAST);
    assign r_hit = (rd_addr_i >= RW_FIRST) && (rd_addr_i <= REG_LAST);
    assign wslot = SLOT_W'(wr_addr_i - RW_FIRST);
    assign rslot = SLOT_W'(rd_addr_i - RW_FIRST);

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && w_hit) mem_d[wslot] = wr_data_i;
    end

    for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= reset_val(g + int'(RW_FIRST));
            else        mem_q[g] <= mem_d[g];
        end
        assign mem_flat[g*8 +: 8] = mem_q[g];
    end

    for (genvar k = 0; k < CTL_NUM; k++) begin : g_ctl
        assign ctl_o[k] = mem_q[k];
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == '0) rd_data_o = pin_state_i;
        else if (r_hit)      rd_data_o = mem_q[rslot];
    end

    // R8
    ro_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !w_hit) |=> $stable(mem_flat));
endmodule

// File: rtl/ledi2c_target.sv
module ledi2c_target
    import ledi2c_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] addr_sel_i,
    input  logic [7:0] pin_state_i,
    output logic [7:0] prescale0_o,
    output logic [7:0] duty0_o,
    output logic [7:0] prescale1_o,
    output logic [7:0] duty1_o,
    output logic [7:0] select_lo_o,
    output logic [7:0] select_hi_o
);
    logic [1:0] raw_lines, flt_lines;
    logic       scl_f, sda_f;

    assign raw_lines = {sda_i, scl_i};
    for (genvar i = 0; i < 2; i++) begin : g_flt
        ledi2c_deglitch #(.LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[i]),
            .dout (flt_lines[i])
        );
    end
    assign scl_f = flt_lines[0];
    assign sda_f = flt_lines[1];

    ctl_s q, d;
    logic [7:0]              rdata;
    logic [CTL_NUM-1:0][7:0] ctl;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic [3:0] next_wr, next_rd;

    assign scl_rise  =  scl_f & ~q.scl_p;
    assign scl_fall  = ~scl_f &  q.scl_p;
    assign bus_start =  q.sda_p & ~sda_f & scl_f & q.scl_p;
    assign bus_stop  = ~q.sda_p &  sda_f & scl_f & q.scl_p;
    assign next_wr   = (q.ptr >= REG_LAST) ? WR_WRAP : q.ptr + 4'd1;
    assign next_rd   = (q.ptr >= REG_LAST) ? RD_WRAP : q.ptr + 4'd1;

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.scl_p = scl_f;
        d.sda_p = sda_f;
        if (bus_start) begin
            d.phase = ST_DEV;
            d.cnt   = '0;
            d.pull  = 1'b0;
        end else if (bus_stop) begin
            d.phase = ST_IDLE;
            d.pull  = 1'b0;
        end else begin
            case (q.phase)
                ST_DEV, ST_PTR, ST_WR: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[6:0], sda_f};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt   = '0;
                        d.pull  = 1'b1;
                        d.phase = ST_ACK;
                        case (q.phase)
                            ST_DEV: begin
                                if (q.shreg[7:1] == {DEV_HI, addr_sel_i}) begin
                                    d.after_ack = q.shreg[0] ? ST_RD : ST_PTR;
                                end else begin
                                    d.pull  = 1'b0;
                                    d.phase = ST_IDLE;
                                end
                            end
                            ST_PTR: begin
                                d.ptr       = q.shreg[3:0];
                                d.inc       = q.shreg[INC_BIT];
                                d.after_ack = ST_WR;
                            end
                            default: begin
                                d.we        = 1'b1;
                                d.waddr     = q.ptr;
                                d.wdata     = q.shreg;
                                d.after_ack = ST_WR;
                                if (q.inc) d.ptr = next_wr;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.phase = q.after_ack;
                        d.cnt   = '0;
                        if (q.after_ack == ST_RD) begin
                            d.shreg = rdata;
                            d.pull  = ~rdata[7];
                        end else begin
                            d.pull  = 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.pull  = 1'b0;
                            d.phase = ST_MACK;
                            d.cnt   = '0;
                            if (q.inc) d.ptr = next_rd;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.pull  = ~q.shreg[6];
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.macked = ~sda_f;
                    end else if (scl_fall) begin
                        if (q.macked) begin
                            d.phase = ST_RD;
                            d.shreg = rdata;
                            d.pull  = ~rdata[7];
                            d.cnt   = '0;
                        end else begin
                            d.phase = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= ST_IDLE;
            q.after_ack <= ST_IDLE;
            q.scl_p     <= 1'b1;
            q.sda_p     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    ledi2c_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (q.we),
        .wr_addr_i  (q.waddr),
        .wr_data_i  (q.wdata),
        .rd_addr_i  (q.ptr),
        .pin_state_i(pin_state_i),
        .rd_data_o  (rdata),
        .ctl_o      (ctl)
    );

    assign sda_pull_o  = q.pull;
    assign prescale0_o = ctl[0];
    assign duty0_o     = ctl[1];
    assign prescale1_o = ctl[2];
    assign duty1_o     = ctl[3];
    assign select_lo_o = ctl[4];
    assign select_hi_o = ctl[5];

    // R7
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pull) |-> !$past(scl_f));

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE) |-> !q.pull);

    // R4
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R2
    ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_ACK) |-> q.pull);
endmodule

// File: tb/ledi2c_target_tb.sv
module ledi2c_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       glitch_mode = 1'b0;
    logic [2:0] addr_sel = 3'b101;
    logic [7:0] pins = 8'h3C;
    logic       sda_pull;
    logic [7:0] psc0, dty0, psc1, dty1, sello, selhi;
    wire        sda_bus = ~(m_sda_low | sda_pull);

    int checks = 0;
    int failures = 0;
    logic [7:0] mdl [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ledi2c_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .pin_state_i(pins),
        .prescale0_o(psc0), .duty0_o(dty0), .prescale1_o(psc1), .duty1_o(dty1),
        .select_lo_o(sello), .select_hi_o(selhi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_q();
        m_scl = 1'b1;     wait_q();
        m_sda_low = 1'b0; wait_q();
    endtask

    task automatic write_bit(input bit b);
        m_sda_low = !b;
        if (glitch_mode) begin
            repeat (3) @(negedge clk);
            m_scl = 1'b1; repeat (2) @(negedge clk);
            m_scl = 1'b0; repeat (Q - 5) @(negedge clk);
        end else wait_q();
        m_scl = 1'b1;
        if (glitch_mode && b) begin
            repeat (4) @(negedge clk);
            m_sda_low = 1'b1; repeat (2) @(negedge clk);
            m_sda_low = 1'b0; repeat (Q - 6) @(negedge clk);
        end else wait_q();
        wait_q();
        m_scl = 1'b0;
        wait_q();
    endtask

    task automatic read_bit(output bit b);
        m_sda_low = 1'b0; wait_q();
        m_scl = 1'b1;     wait_q();
        b = sda_bus;      wait_q();
        m_scl = 1'b0;     wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) write_bit(v[i]);
        read_bit(x);
        ack = !x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            read_bit(x);
            v[i] = x;
        end
        write_bit(!ack);
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1100, addr_sel, rd};
    endfunction

    function automatic logic [3:0] adv(input logic [3:0] p, input bit rd);
        if (p >= 4'd9) return rd ? 4'd0 : 4'd2;
        return p + 4'd1;
    endfunction

    function automatic logic [7:0] mdl_read(input logic [3:0] p);
        if (p == 4'd0) return pins;
        if (p >= 4'd2 && p <= 4'd9) return mdl[p];
        return 8'h00;
    endfunction

    task automatic check_outputs(input string req);
        chk(psc0  == mdl[2], req, psc0,  mdl[2]);
        chk(dty0  == mdl[3], req, dty0,  mdl[3]);
        chk(psc1  == mdl[4], req, psc1,  mdl[4]);
        chk(dty1  == mdl[5], req, dty1,  mdl[5]);
        chk(sello == mdl[6], req, sello, mdl[6]);
        chk(selhi == mdl[7], req, selhi, mdl[7]);
    endtask

    task automatic do_write(input logic [3:0] p, input bit inc, input int n,
                            input logic [7:0] seed, input string req);
        bit a, all_ack;
        logic [3:0] cp = p;
        logic [7:0] v;
        all_ack = 1'b1;
        bus_start();
        send_byte(dev(0), a);               all_ack &= a;
        send_byte({3'b000, inc, p}, a);     all_ack &= a;
        for (int i = 0; i < n; i++) begin
            v = seed + 8'(i * 29);
            send_byte(v, a);                all_ack &= a;
            if (cp >= 4'd2 && cp <= 4'd9) mdl[cp] = v;
            if (inc) cp = adv(cp, 0);
        end
        bus_stop();
        chk(all_ack, req, all_ack, 1);
    endtask

    task automatic do_read(input logic [3:0] p, input bit inc, input int n, input string req);
        bit a, all_ack;
        logic [3:0] cp = p;
        logic [7:0] v;
        all_ack = 1'b1;
        bus_start();
        send_byte(dev(0), a);               all_ack &= a;
        send_byte({3'b000, inc, p}, a);     all_ack &= a;
        bus_start();
        send_byte(dev(1), a);               all_ack &= a;
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            chk(v == mdl_read(cp), req, v, mdl_read(cp));
            if (inc) cp = adv(cp, 1);
        end
        bus_stop();
        chk(all_ack, req, all_ack, 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit a, x;
        logic [7:0] v;
        for (int i = 0; i < 16; i++) mdl[i] = (i == 3 || i == 5) ? 8'h80 : 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 reset state
        check_outputs("R9 reset");
        chk(sda_pull == 1'b0, "R9 sda released", sda_pull, 0);

        // R2 / R3 address sweep
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            bus_stop();
            chk(a == (ad == {4'b1100, addr_sel}), "R2 address match", a, ad == {4'b1100, addr_sel});
        end

        addr_sel = 3'b010;

        // R3 mismatch then data: no ack, no effect
        bus_start();
        send_byte({4'b1100, 3'b011, 1'b0}, a);
        send_byte(8'h16, x);
        send_byte(8'hEE, x);
        bus_stop();
        chk(!a && !x, "R3 no ack after mismatch", {a, x}, 0);
        check_outputs("R3 registers untouched");

        // R4 R5 R7 R8 R12 sweep of every start pointer with auto-advance
        for (int p = 0; p < 16; p++) begin
            do_write(4'(p), 1'b1, 2, 8'(p * 17 + 3), "R4 write ack");
            do_read(4'(p), 1'b1, 3, "R7 read with wrap");
        end
        check_outputs("R4 outputs after sweep");

        // R5 write wrap 0x09 -> 0x02
        do_write(4'd8, 1'b1, 4, 8'h41, "R5 write wrap ack");
        check_outputs("R5 wrap to 0x02");
        chk(dty0 == 8'h41 + 8'(3 * 29), "R5 fourth byte at 0x03", dty0, 8'h41 + 8'(3 * 29));

        // R6 fixed pointer
        do_write(4'd6, 1'b0, 3, 8'h11, "R6 write ack");
        chk(sello == 8'h11 + 8'(2 * 29), "R6 last byte kept", sello, 8'h11 + 8'(2 * 29));
        chk(selhi == mdl[7], "R6 neighbour untouched", selhi, mdl[7]);
        do_read(4'd7, 1'b0, 3, "R6 repeated read");

        // R12 scratch
        do_write(4'd8, 1'b1, 2, 8'hC3, "R12 write ack");
        do_read(4'd8, 1'b1, 2, "R12 readback");
        check_outputs("R12 no output effect");

        // R8 discarded writes and fixed reads
        do_write(4'd0, 1'b0, 2, 8'h99, "R8 ro write ack");
        do_write(4'd1, 1'b0, 2, 8'h77, "R8 ro write ack");
        do_write(4'd12, 1'b1, 3, 8'h5A, "R8 unmapped write ack");
        check_outputs("R8 discarded");
        pins = 8'hA6;
        do_read(4'd0, 1'b1, 2, "R8 pins and zero");
        do_read(4'd13, 1'b0, 2, "R8 unmapped reads zero");

        // R7 read wrap 0x09 -> 0x00 -> 0x01
        do_read(4'd9, 1'b1, 3, "R7 wrap to 0x00");

        // R10 nack ends read, extra clocks see released SDA
        bus_start();
        send_byte(dev(0), a);
        send_byte(8'h13, a);
        bus_start();
        send_byte(dev(1), a);
        recv_byte(v, 1'b0);
        chk(v == mdl[3], "R10 byte before nack", v, mdl[3]);
        for (int i = 0; i < 9; i++) begin
            read_bit(x);
            chk(x == 1'b1, "R10 released after nack", x, 1);
        end
        bus_stop();

        // R1 repeated START mid-byte discards the partial byte
        bus_start();
        send_byte(dev(0), a);
        send_byte(8'h04, a);
        for (int i = 0; i < 4; i++) write_bit(1'b0);
        bus_start();
        send_byte(dev(0), a);
        send_byte(8'h05, x);
        send_byte(8'h3E, x);
        bus_stop();
        mdl[5] = 8'h3E;
        chk(a && x, "R1 ack after restart", {a, x}, 3);
        check_outputs("R1 partial byte dropped");

        // R11 short spikes on both lines
        bus_start();
        send_byte(dev(0), a);
        send_byte(8'h09, a);
        glitch_mode = 1'b1;
        send_byte(8'hB6, x);
        glitch_mode = 1'b0;
        bus_stop();
        mdl[9] = 8'hB6;
        chk(x, "R11 ack through spikes", x, 1);
        do_read(4'd9, 1'b0, 1, "R11 data through spikes");
        check_outputs("R11 outputs");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule